// File: doc/BRIEF.md
# Bi-quinary decade counter

This block is a four-bit decade counter built from two counting stages that keep their own state: a one-bit divide-by-two stage whose output is `qA`, and a three-bit divide-by-five stage whose outputs are `qD`, `qC` and `qB`. Each stage has its own count-enable input. A two-bit chaining mode selects how the stages are linked. In split mode each stage follows only its own enable, so logic outside the block can chain them in any order. In BCD mode the divide-by-two stage drives the divide-by-five stage, which gives a binary-coded decimal count. In symmetric mode the divide-by-five stage drives the divide-by-two stage, which gives a divide-by-ten square wave on `qA` with equal high and low times.

The whole block is synchronous to one clock. Count enables replace the ripple clocks. A stage that is chained behind another advances in the same clock edge in which its driving bit falls from 1 to 0. That falling edge is found in advance from the present state and the driving stage's enable, so the outputs never show an intermediate value. A synchronous clear input and a synchronous load-nine input force the count, and clear wins when both are asserted. A terminal-count flag marks the value nine while the block is in BCD mode.

Top module: `decade_divider`

## Requirements
- R1: While `rst_n` is low, `qA`, `qB`, `qC` and `qD` are all 0. After reset is released they stay 0 until a count, clear or load input acts.
- R2: In split mode (`chainMode` = 2'b00 or 2'b11), every clock with `cntEnB`=1 advances `{qD,qC,qB}` through 000, 001, 010, 011, 100 and then wraps to 000.
- R3: In split mode, every clock with `cntEnA`=1 inverts `qA`, independent of `cntEnB`.
- R4: In BCD mode (`chainMode` = 2'b01), every clock with `cntEnA`=1 increments `{qD,qC,qB,qA}` by one from 0 to 9, and 9 wraps to 0. `cntEnB` has no effect in this mode.
- R5: In symmetric mode (`chainMode` = 2'b10), `cntEnB` advances the divide-by-five stage, and `qA` inverts in the same edge where `qD` falls from 1 to 0. Over ten enabled clocks `qA` is high for five and low for five. `cntEnA` has no effect in this mode.
- R6: `clearAll`=1 makes all four outputs 0 at the next clock edge, whatever the mode, the enables or `loadNine` are.
- R7: `loadNine`=1 with `clearAll`=0 loads `qD`=1, `qC`=0, `qB`=0, `qA`=1 at the next clock edge, whatever the enables are.
- R8: `termCount` is 1 exactly when `chainMode` is 2'b01 and `{qD,qC,qB,qA}` = 4'b1001, and is 0 otherwise.
- R9: A clock in which neither enable is asserted and neither clear nor load is asserted leaves all four outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chainMode | input | 2 | 00/11 split, 01 BCD, 10 symmetric |
| cntEnA | input | 1 | Count enable of the divide-by-two stage |
| cntEnB | input | 1 | Count enable of the divide-by-five stage |
| clearAll | input | 1 | Synchronous clear to zero, highest priority |
| loadNine | input | 1 | Synchronous load of the value nine |
| qA | output | 1 | Divide-by-two stage output |
| qB | output | 1 | Divide-by-five stage bit 0 |
| qC | output | 1 | Divide-by-five stage bit 1 |
| qD | output | 1 | Divide-by-five stage bit 2 |
| termCount | output | 1 | High while BCD mode shows nine |

## Verification
The counting, clear and load results (R2 to R7, R9) are registered and appear one clock edge after the cycle in which the inputs were presented, including the chained advance of the second stage. `termCount` (R8) is combinational from the outputs and the mode, so it is valid in the same cycle as the count it flags. The bench changes its inputs on the falling edge, lets exactly one rising edge pass, and compares the outputs and the flag on the next falling edge with a reference model stepped once per cycle. The duty-cycle check for symmetric mode counts `qA` high samples over twenty enabled clocks.

// File: rtl/decade_pkg.sv
package decade_pkg;

  localparam int TWO_MOD  = 2;
  localparam int FIVE_MOD = 5;
  localparam int FIVE_W   = $clog2(FIVE_MOD);

  typedef enum logic [1:0] {
    MODE_SPLIT     = 2'b00,
    MODE_BCD       = 2'b01,
    MODE_SYM       = 2'b10,
    MODE_SPLIT_ALT = 2'b11
  } chain_mode_e;

  typedef struct packed {
    logic clear;
    logic loadNine;
    logic stepTwo;
    logic stepFive;
  } stage_strobe_t;

endpackage

// File: rtl/decade_ctrl.sv
module decade_ctrl
  import decade_pkg::*;
(
  input  logic [1:0]    chainMode,
  input  logic          cntEnA,
  input  logic          cntEnB,
  input  logic          clearAll,
  input  logic          loadNine,
  input  logic          twoBit,
  input  logic          fiveAtTop,
  output stage_strobe_t strobe
);

  chain_mode_e modeSel;
  logic        twoFalls;
  logic        fiveFalls;

  assign modeSel = chain_mode_e'(chainMode);

  // a stage output falls when it is about to leave its top state
  assign twoFalls  = cntEnA && twoBit;
  assign fiveFalls = cntEnB && fiveAtTop;

  always_comb begin
    strobe          = '0;
    strobe.clear    = clearAll;
    strobe.loadNine = loadNine && !clearAll;
    unique case (modeSel)
      MODE_BCD: begin
        strobe.stepTwo  = cntEnA;
        strobe.stepFive = twoFalls;
      end
      MODE_SYM: begin
        strobe.stepTwo  = fiveFalls;
        strobe.stepFive = cntEnB;
      end
      default: begin
        strobe.stepTwo  = cntEnA;
        strobe.stepFive = cntEnB;
      end
    endcase
  end

endmodule

// File: rtl/decade_datapath.sv
module decade_datapath
  import decade_pkg::*;
#(
  parameter int FIVE_LEN = FIVE_MOD
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  stage_strobe_t         strobe,
  output logic                  twoBit,
  output logic [FIVE_W-1:0]     fiveVal,
  output logic                  fiveAtTop
);

  localparam logic [FIVE_W-1:0] FIVE_TOP = FIVE_W'(FIVE_LEN - 1);

  logic [FIVE_W-1:0] fiveNext;

  assign fiveAtTop = (fiveVal == FIVE_TOP);
  assign fiveNext  = fiveAtTop ? '0 : fiveVal + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twoBit <= 1'b0;
    end else if (strobe.clear) begin
      twoBit <= 1'b0;
    end else if (strobe.loadNine) begin
      twoBit <= 1'b1;
    end else if (strobe.stepTwo) begin
      twoBit <= ~twoBit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiveVal <= '0;
    end else if (strobe.clear) begin
      fiveVal <= '0;
    end else if (strobe.loadNine) begin
      fiveVal <= FIVE_TOP;
    end else if (strobe.stepFive) begin
      fiveVal <= fiveNext;
    end
  end

endmodule

// File: rtl/decade_divider.sv
module decade_divider
  import decade_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] chainMode,
  input  logic       cntEnA,
  input  logic       cntEnB,
  input  logic       clearAll,
  input  logic       loadNine,
  output logic       qA,
  output logic       qB,
  output logic       qC,
  output logic       qD,
  output logic       termCount
);

  stage_strobe_t     strobe;
  logic              twoBit;
  logic [FIVE_W-1:0] fiveVal;
  logic              fiveAtTop;

  decade_ctrl u_ctrl (
    .chainMode (chainMode),
    .cntEnA    (cntEnA),
    .cntEnB    (cntEnB),
    .clearAll  (clearAll),
    .loadNine  (loadNine),
    .twoBit    (twoBit),
    .fiveAtTop (fiveAtTop),
    .strobe    (strobe)
  );

  decade_datapath #(.FIVE_LEN(FIVE_MOD)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .twoBit    (twoBit),
    .fiveVal   (fiveVal),
    .fiveAtTop (fiveAtTop)
  );

  assign qA = twoBit;
  assign qB = fiveVal[0];
  assign qC = fiveVal[1];
  assign qD = fiveVal[2];

  assign termCount = (chain_mode_e'(chainMode) == MODE_BCD) && qD && !qC && !qB && qA;

endmodule

// File: rtl/decade_divider_chk.sv
module decade_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] chainMode,
  input logic       cntEnA,
  input logic       cntEnB,
  input logic       clearAll,
  input logic       loadNine,
  input logic       qA,
  input logic       qB,
  input logic       qC,
  input logic       qD,
  input logic       termCount
);

  logic [3:0] cnt;
  logic       quiet;
  assign cnt   = {qD, qC, qB, qA};
  assign quiet = !clearAll && !loadNine;

  a_r2_five_range: assert property (@(posedge clk) disable iff (!rst_n)
    {qD, qC, qB} <= 3'd4);

  a_r6_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clearAll |=> cnt == 4'd0);

  a_r7_load_nine: assert property (@(posedge clk) disable iff (!rst_n)
    (loadNine && !clearAll) |=> cnt == 4'd9);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !cntEnA && !cntEnB) |=> $stable(cnt));

  a_r4_bcd_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && chainMode == 2'b01 && cntEnA && cnt == 4'd9) |=> cnt == 4'd0);

  a_r5_sym_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && chainMode == 2'b10 && cntEnB && {qD, qC, qB} == 3'b100) |=> qA != $past(qA));

  a_r8_term_bcd_only: assert property (@(posedge clk) disable iff (!rst_n)
    termCount |-> (chainMode == 2'b01 && cnt == 4'd9));

endmodule

bind decade_divider decade_divider_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .chainMode (chainMode),
  .cntEnA    (cntEnA),
  .cntEnB    (cntEnB),
  .clearAll  (clearAll),
  .loadNine  (loadNine),
  .qA        (qA),
  .qB        (qB),
  .qC        (qC),
  .qD        (qD),
  .termCount (termCount)
);

// File: tb/sim_decade_divider.sv
`timescale 1ns/1ps
module sim_decade_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] chainMode = 2'b00;
  logic       cntEnA = 1'b0, cntEnB = 1'b0, clearAll = 1'b0, loadNine = 1'b0;
  logic       qA, qB, qC, qD, termCount;

  int checks = 0;
  int fails  = 0;
  logic [3:0] expQ = 4'd0;
  bit finished = 0;

  always #10 clk = ~clk;

  decade_divider u0 (
    .clk(clk), .rst_n(rst_n), .chainMode(chainMode), .cntEnA(cntEnA),
    .cntEnB(cntEnB), .clearAll(clearAll), .loadNine(loadNine),
    .qA(qA), .qB(qB), .qC(qC), .qD(qD), .termCount(termCount)
  );

  function automatic logic [3:0] modelNext(logic [3:0] q, logic [1:0] m,
                                           logic a, logic b, logic c, logic l);
    logic       two, sA, sB;
    logic [2:0] five;
    if (c) return 4'd0;
    if (l) return 4'd9;
    two  = q[0];
    five = q[3:1];
    case (m)
      2'b01:   begin sA = a; sB = a && two; end
      2'b10:   begin sB = b; sA = b && (five == 3'd4); end
      default: begin sA = a; sB = b; end
    endcase
    if (sA) two = ~two;
    if (sB) five = (five == 3'd4) ? 3'd0 : five + 3'd1;
    return {five, two};
  endfunction

  function automatic logic modelTerm(logic [3:0] q, logic [1:0] m);
    return (m == 2'b01) && (q == 4'd9);
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string reqOf(logic [1:0] m, logic a, logic b, logic c, logic l);
    if (c) return "R6";
    if (l) return "R7";
    if (!a && !b) return "R9";
    if (m == 2'b01) return "R4";
    if (m == 2'b10) return "R5";
    return b ? "R2" : "R3";
  endfunction

  // called at a falling edge; returns at the next falling edge after checking
  task automatic cycle(logic a, logic b, logic c, logic l);
    string tag;
    cntEnA = a; cntEnB = b; clearAll = c; loadNine = l;
    tag  = reqOf(chainMode, a, b, c, l);
    expQ = modelNext(expQ, chainMode, a, b, c, l);
    @(negedge clk);
    check(tag, {qD, qC, qB, qA}, expQ);
    check("R8", {3'b000, termCount}, {3'b000, modelTerm(expQ, chainMode)});
  endtask

  initial begin
    #(20ns * 150000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int highs;
    void'($urandom(32'd1234));
    cntEnA = 1'b1; cntEnB = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {qD, qC, qB, qA}, 4'd0);
    rst_n = 1'b1;
    cntEnA = 1'b0; cntEnB = 1'b0;
    @(negedge clk);
    check("R1", {qD, qC, qB, qA}, 4'd0);

    // R4 directed: BCD count through wrap, cntEnB ignored
    chainMode = 2'b01;
    for (int i = 0; i < 12; i++) cycle(1'b1, i[0], 1'b0, 1'b0);
    // R2 / R3 directed in split mode
    chainMode = 2'b00;
    cycle(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 7; i++) cycle(1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b0, 1'b0);
    // R6 priority over R7
    cycle(1'b1, 1'b1, 1'b1, 1'b1);
    // R7 load then R8 flag in BCD
    chainMode = 2'b11;
    cycle(1'b1, 1'b1, 1'b0, 1'b1);
    chainMode = 2'b01;
    cycle(1'b0, 1'b0, 1'b0, 1'b0);
    // R5 symmetric duty over twenty enabled clocks
    chainMode = 2'b10;
    cycle(1'b0, 1'b0, 1'b1, 1'b0);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1'b1, 1'b1, 1'b0, 1'b0);
      if (qA) highs++;
    end
    check("R5", 4'(highs), 4'd10);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ((i % 150) == 0) chainMode = 2'($urandom_range(0, 3));
      cycle(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            ($urandom_range(0, 49) == 0), ($urandom_range(0, 39) == 0));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule